// File: doc/BRIEF.md
# Locked Cycle Cache Bus Sequencer

This block decides how each processor bus cycle is run when a write-through cache sits between the processor-side bus and the shared system bus. For every request it looks at read/write, the processor's lock level, cacheability, the local-bus-access flag and the directory hit result. It then either completes the cycle locally or runs it on the system bus. It also produces the strobes that write cache data and set directory entries.

Locked traffic is handled differently from normal traffic. A locked cycle always goes out on the system bus, even when it hits. The system-bus lock output is held for the whole locked run, and hold requests from other masters wait until the run ends. A locked read hit gets its data from main memory and writes that data back into the cache line without changing the directory. Writes are posted: the processor is released at once, and a write-buffer status flag stays high until the system bus acknowledges the write. The system-bus ready input ends every system-bus cycle.

Top module: `lsq_top`

## Requirements
- R1: A non-local cycle with `cpu_lock` high runs on the system bus even on a hit. `sys_ads` is high for exactly one cycle, the cycle after acceptance. A request is accepted on a rising edge where the block is idle, `req_valid` is high, `cpu_ready` is low and `hold_ack` is low.
- R2: A cycle with `req_local` high never raises `sys_ads`. `cpu_ready` pulses in the cycle after acceptance, and no cache strobe fires.
- R3: An unlocked cacheable read hit is served locally. `cpu_ready` pulses in the cycle after acceptance, with no `sys_ads` and no cache strobe.
- R4: `sys_lock` rises together with `sys_ads` of the first locked system cycle. It stays high while `cpu_lock` stays high, and falls one cycle after `cpu_lock` is seen low while the block is idle.
- R5: `hold_ack` is never granted while `sys_lock` or `cpu_lock` is high. Otherwise it is granted one cycle after `hold_req` in an idle cycle with no pending request, and no `sys_ads` occurs while it is high.
- R6: A cacheable read miss, locked or not, returns `cpu_ready` in the cycle after `sys_rdy`. `cache_wr` and `dir_upd` pulse in that same cycle.
- R7: A locked cacheable read hit pulses `cache_wr` together with `cpu_ready` in the cycle after `sys_rdy`, and `dir_upd` stays low.
- R8: A cacheable system-bound write hit pulses `cache_wr` in the cycle after acceptance, without `dir_upd`. A write miss fires no cache strobe.
- R9: `sys_miss` is high only for cacheable read or write misses. It is valid from the `sys_ads` cycle until the cycle after `sys_rdy`, where it returns low.
- R10: `sys_miss_oe` is low (output floated) exactly while `hold_ack` is high.
- R11: Writes are posted. For a system-bound write, `cpu_ready` and `wbs` go high in the cycle after acceptance, and `wbs` goes low in the cycle after `sys_rdy`.
- R12: A non-cacheable read runs on the system bus and returns `cpu_ready` in the cycle after `sys_rdy`, with no cache strobe.
- R13: While `rst_n` is low, `sys_ads`, `sys_lock`, `sys_miss`, `cpu_ready`, `wbs`, `hold_ack`, `cache_wr` and `dir_upd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor cycle request, held until `cpu_ready` |
| req_addr | input | ADDR_W | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| cpu_lock | input | 1 | Processor lock level, held across a locked sequence |
| req_cache | input | 1 | Address is cacheable |
| req_local | input | 1 | Cycle is claimed by a local-bus device |
| req_hit | input | 1 | Directory hit for this address |
| cpu_ready | output | 1 | Ends the processor cycle |
| sys_ads | output | 1 | System-bus address strobe |
| sys_addr | output | ADDR_W | System-bus address |
| sys_write | output | 1 | System-bus direction |
| sys_rdy | input | 1 | System-bus ready, ends the system cycle |
| sys_lock | output | 1 | System-bus lock |
| sys_miss | output | 1 | Cacheable miss status |
| sys_miss_oe | output | 1 | Output enable for `sys_miss` |
| hold_req | input | 1 | Another master requests the system bus |
| hold_ack | output | 1 | Bus handed to the other master |
| wbs | output | 1 | Posted write pending |
| cache_wr | output | 1 | Cache data write strobe |
| dir_upd | output | 1 | Directory set-valid strobe |

## Verification
The bench goes after the locked read hit. A design that skips the system bus there returns stale data, and one that also sets the directory gives itself away through `dir_upd`. It raises a hold request during a locked run: a design that grants it would let another master break the run, and one that drops `sys_lock` between the locked cycles would show it at the next `sys_ads`. It also checks that `sys_miss` stays low on locked hits and non-cacheable cycles, and that `wbs` falls only after `sys_rdy`, so an early-clearing write buffer shows up. Random mixes of lock, cacheability, hit and ready delays are checked against a bench model of every strobe's cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SYS = 1'b1} seq_st_t;

  typedef struct packed {
    logic to_sys;   // cycle must run on the system bus
    logic write;
    logic miss;     // cacheable miss status
    logic fill;     // write returned read data into the cache
    logic dir_set;  // set the directory entry valid
    logic wr_upd;   // write hit updates cache data
  } route_t;
endpackage

// File: rtl/lsq_route.sv
module lsq_route
  import lsq_pkg::*;
(
  input  logic   write,
  input  logic   lock,
  input  logic   cache,
  input  logic   hit,
  input  logic   local_acc,
  output route_t route
);
  logic local_srv;

  always_comb begin
    local_srv      = local_acc | (~write & cache & hit & ~lock);
    route.to_sys   = ~local_srv;
    route.write    = write;
    route.miss     = cache & ~hit & ~local_acc;
    route.fill     = ~write & cache & ~local_acc;
    route.dir_set  = ~write & cache & ~hit & ~local_acc;
    route.wr_upd   = write & cache & hit & ~local_acc;
  end
endmodule

// File: rtl/lsq_lockhold.sv
module lsq_lockhold (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic pending,
  input  logic lock_start,
  input  logic cpu_lock,
  input  logic hold_req,
  output logic lock_seq,
  output logic hold_ack
);
  logic lock_d, hold_d;

  always_comb begin
    lock_d = lock_seq;
    if (lock_start)            lock_d = 1'b1;
    else if (idle && !cpu_lock) lock_d = 1'b0;

    hold_d = hold_ack;
    if (hold_ack)              hold_d = hold_req;
    else if (hold_req && idle && !pending && !lock_seq && !cpu_lock)
                               hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_seq <= 1'b0;
      hold_ack <= 1'b0;
    end else begin
      lock_seq <= lock_d;
      hold_ack <= hold_d;
    end
  end

  // R5
  hold_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack && lock_seq));
endmodule

// File: rtl/lsq_wbuf.sv
module lsq_wbuf (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_wr,
  input  logic wr_done,
  input  logic sys_rdy,
  output logic wbs
);
  logic wbs_d;

  always_comb begin
    wbs_d = wbs;
    if (latch_wr)     wbs_d = 1'b1;
    else if (wr_done) wbs_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbs <= 1'b0;
    else        wbs <= wbs_d;
  end

  // R11
  wbs_fall_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wbs) |-> $past(sys_rdy));
endmodule

// File: rtl/lsq_top.sv
module lsq_top
  import lsq_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              cpu_lock,
  input  logic              req_cache,
  input  logic              req_local,
  input  logic              req_hit,
  output logic              cpu_ready,
  output logic              sys_ads,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              sys_write,
  input  logic              sys_rdy,
  output logic              sys_lock,
  output logic              sys_miss,
  output logic              sys_miss_oe,
  input  logic              hold_req,
  output logic              hold_ack,
  output logic              wbs,
  output logic              cache_wr,
  output logic              dir_upd
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_i = rst_sync[SYNC_N-1];

  seq_st_t st, st_d;
  route_t  rt_in, cur, cur_d;
  logic    accept, idle, done;
  logic    rdy_d, ads_d, miss_d, cwr_d, dir_d;
  logic    [ADDR_W-1:0] addr_d;
  logic    wr_d;

  lsq_route u_route (
    .write(req_write), .lock(cpu_lock), .cache(req_cache),
    .hit(req_hit), .local_acc(req_local), .route(rt_in)
  );

  assign idle   = (st == ST_IDLE);
  assign accept = idle && req_valid && !cpu_ready && !hold_ack;
  assign done   = (st == ST_SYS) && sys_rdy;

  lsq_lockhold u_lock (
    .clk(clk), .rst_n(rst_i), .idle(idle),
    .pending(req_valid && !cpu_ready),
    .lock_start(accept && cpu_lock && rt_in.to_sys),
    .cpu_lock(cpu_lock), .hold_req(hold_req),
    .lock_seq(sys_lock), .hold_ack(hold_ack)
  );

  lsq_wbuf u_wbuf (
    .clk(clk), .rst_n(rst_i),
    .latch_wr(accept && rt_in.to_sys && rt_in.write),
    .wr_done(done && cur.write), .sys_rdy(sys_rdy), .wbs(wbs)
  );

  always_comb begin
    st_d   = st;
    cur_d  = cur;
    addr_d = sys_addr;
    wr_d   = sys_write;
    miss_d = sys_miss;
    rdy_d  = 1'b0;
    ads_d  = 1'b0;
    cwr_d  = 1'b0;
    dir_d  = 1'b0;
    if (accept) begin
      cur_d = rt_in;
      if (rt_in.to_sys) begin
        st_d   = ST_SYS;
        ads_d  = 1'b1;
        addr_d = req_addr;
        wr_d   = req_write;
        miss_d = rt_in.miss;
        rdy_d  = rt_in.write;
        cwr_d  = rt_in.wr_upd;
      end else begin
        rdy_d  = 1'b1;
      end
    end else if (done) begin
      st_d   = ST_IDLE;
      miss_d = 1'b0;
      if (!cur.write) begin
        rdy_d = 1'b1;
        cwr_d = cur.fill;
        dir_d = cur.dir_set;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st        <= ST_IDLE;
      cur       <= '0;
      sys_addr  <= '0;
      sys_write <= 1'b0;
      sys_miss  <= 1'b0;
      cpu_ready <= 1'b0;
      sys_ads   <= 1'b0;
      cache_wr  <= 1'b0;
      dir_upd   <= 1'b0;
    end else begin
      st        <= st_d;
      cur       <= cur_d;
      sys_addr  <= addr_d;
      sys_write <= wr_d;
      sys_miss  <= miss_d;
      cpu_ready <= rdy_d;
      sys_ads   <= ads_d;
      cache_wr  <= cwr_d;
      dir_upd   <= dir_d;
    end
  end

  assign sys_miss_oe = !hold_ack;

  // R1
  ads_single_chk: assert property (@(posedge clk) disable iff (!rst_i)
    sys_ads |=> !sys_ads);
  // R5
  no_ads_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    hold_ack |-> !sys_ads);
  // R6
  dir_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_i)
    dir_upd |-> (cache_wr && cpu_ready));
  // R9
  miss_in_sys_chk: assert property (@(posedge clk) disable iff (!rst_i)
    sys_miss |-> (st == ST_SYS));
endmodule

// File: tb/tb_lsq_top.sv
`timescale 1ns/1ps
module tb_lsq_top;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, cpu_lock, req_cache, req_local, req_hit;
  logic [AW-1:0] req_addr;
  logic sys_rdy, hold_req;
  logic cpu_ready, sys_ads, sys_write, sys_lock, sys_miss, sys_miss_oe;
  logic hold_ack, wbs, cache_wr, dir_upd;
  logic [AW-1:0] sys_addr;

  int errors = 0;
  int checks = 0;
  logic exp_lock = 1'b0;

  always #5 clk = ~clk;

  lsq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .cpu_lock(cpu_lock), .req_cache(req_cache),
    .req_local(req_local), .req_hit(req_hit), .cpu_ready(cpu_ready),
    .sys_ads(sys_ads), .sys_addr(sys_addr), .sys_write(sys_write),
    .sys_rdy(sys_rdy), .sys_lock(sys_lock), .sys_miss(sys_miss),
    .sys_miss_oe(sys_miss_oe), .hold_req(hold_req), .hold_ack(hold_ack),
    .wbs(wbs), .cache_wr(cache_wr), .dir_upd(dir_upd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_sys(input logic w, lk, c, h, l);
    return !(l || (!w && c && h && !lk));
  endfunction

  task automatic run_cycle(input logic w, lk, c, h, l, input int dly);
    logic to_sys, miss, fill, dset;
    logic [AW-1:0] a;
    to_sys = f_sys(w, lk, c, h, l);
    miss   = c && !h && !l;
    fill   = !w && c && !l;
    dset   = !w && c && !h && !l;
    a      = AW'($urandom);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; cpu_lock = lk; req_cache = c;
    req_hit = h; req_local = l; req_addr = a;
    exp_lock = lk ? (exp_lock || to_sys) : 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 sys_lock", 32'(sys_lock), 32'(exp_lock));
    if (to_sys) begin
      chk("R1 sys_ads", 32'(sys_ads), 1);
      chk("R1 sys_addr", 32'(sys_addr), 32'(a));
      chk("R9 sys_miss", 32'(sys_miss), 32'(miss));
      chk("R11 cpu_ready posted", 32'(cpu_ready), 32'(w));
      chk("R11 wbs set", 32'(wbs), 32'(w));
      chk("R8 cache_wr write", 32'(cache_wr), 32'(w && c && h));
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R1 sys_ads once", 32'(sys_ads), 0);
        chk("R9 sys_miss held", 32'(sys_miss), 32'(miss));
        chk("R6 no early ready", 32'(cpu_ready), 0);
      end
      sys_rdy = 1'b1;
      @(negedge clk);
      sys_rdy = 1'b0;
      chk("R12 cpu_ready after rdy", 32'(cpu_ready), 32'(!w));
      chk("R7 cache_wr fill", 32'(cache_wr), 32'(fill));
      chk("R6 dir_upd", 32'(dir_upd), 32'(dset));
      chk("R11 wbs clear", 32'(wbs), 0);
      chk("R9 sys_miss clear", 32'(sys_miss), 0);
      chk("R4 sys_lock held", 32'(sys_lock), 32'(exp_lock));
    end else begin
      chk("R2 no sys_ads", 32'(sys_ads), 0);
      chk("R3 cpu_ready local", 32'(cpu_ready), 1);
      chk("R3 no cache_wr", 32'(cache_wr), 0);
      chk("R3 no dir_upd", 32'(dir_upd), 0);
    end
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 0; req_write = 0; cpu_lock = 0; req_cache = 0;
    req_local = 0; req_hit = 0; req_addr = '0; sys_rdy = 0; hold_req = 0;
    repeat (3) @(negedge clk);
    chk("R13 reset outputs",
        32'({sys_ads, sys_lock, sys_miss, cpu_ready, wbs, hold_ack, cache_wr, dir_upd}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_cycle(0, 0, 1, 1, 0, 1);  // R3 unlocked read hit
    run_cycle(0, 0, 1, 0, 0, 2);  // R6 read miss
    run_cycle(0, 1, 1, 1, 0, 1);  // R7 locked read hit, starts locked run
    run_cycle(1, 1, 1, 1, 0, 0);  // R8 locked write hit, lock held
    run_cycle(0, 1, 1, 0, 0, 3);  // R6 locked read miss
    // R5 hold requested inside locked run
    @(negedge clk); hold_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 no hold during lock", 32'(hold_ack), 0);
    chk("R10 miss driven", 32'(sys_miss_oe), 1);
    cpu_lock = 1'b0; exp_lock = 1'b0;
    @(negedge clk);
    chk("R4 lock released", 32'(sys_lock), 0);
    @(negedge clk);
    chk("R5 hold granted", 32'(hold_ack), 1);
    chk("R10 miss floated", 32'(sys_miss_oe), 0);
    req_valid = 1'b1; req_write = 1'b0; req_cache = 1'b0; req_local = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 no ads in hold", 32'(sys_ads), 0);
    chk("R5 request waits", 32'(cpu_ready), 0);
    req_valid = 1'b0; hold_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 miss driven again", 32'(sys_miss_oe), 1);
    run_cycle(1, 0, 1, 0, 0, 1);  // R8 write miss
    run_cycle(0, 0, 0, 0, 0, 0);  // R12 non-cacheable read
    run_cycle(0, 1, 1, 1, 1, 0);  // R2 locked but local
    run_cycle(1, 0, 0, 1, 1, 0);  // R2 local write

    // random mix
    for (int n = 0; n < 300; n++) begin
      run_cycle(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'(($urandom % 5) == 0), int'($urandom % 4));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule